// File: doc/BRIEF.md
# Clock Synthesizer Control Register with Lock Sequencer

This block holds the single control word for one frequency synthesizer: an enable bit and the feedback (M), pre-divider (P) and post-divider (S) settings, together with a read-only flag that reports whether the synthesizer output can be trusted. Software writes the whole word in one access. The block drives the enable and divider settings straight to the analog loop and reads the word back through a plain data bus.

A programmable settle timer models the time the loop needs to lock. The timer starts when the synthesizer is switched on, and again when the M or P setting changes while it is running. A change that touches only S is applied with no settle wait. A request to enter a low-power state switches the synthesizer off at once. A write that carries an out-of-range divider is dropped in full and sets a sticky error flag.

Top module: `pll_ctl_top`

## Requirements
- R1: After reset, pll_en=0, M=200 (0xC8), P=3, S=1, pll_locked=0 and cfg_err=0, so rd_data reads 0x00C80301.
- R2: The word layout is enable at bit 31, lock flag at bit 29 (read-only), M at bits 25:16, P at bits 13:8 and S at bits 2:0. Every other bit reads 0. Write data on bit 29 and on the other bits outside these fields has no effect.
- R3: When a legal write sets the enable bit while the block is disabled, pll_en rises on the capturing edge. pll_locked rises exactly LOCK_CYCLES cycles later.
- R4: A legal, enabled write that changes M or P while enabled clears pll_locked on the capturing edge and restarts the full LOCK_CYCLES wait.
- R5: A legal, enabled write that changes only S updates pll_s on the capturing edge. It leaves pll_locked and any running wait untouched.
- R6: A legal write with the enable bit at 0 clears pll_en and pll_locked on the capturing edge. A later enable waits the full LOCK_CYCLES again.
- R7: While lowpwr_req is high, pll_en and pll_locked go to 0 on the next edge, even when a simultaneous write sets the enable bit. Divider fields of a simultaneous legal write are still taken.
- R8: A write with M outside 64..1023, P outside 1..63 or S outside 1..5 changes no field. It sets cfg_err, which stays set until reset.
- R9: Boundary values M=64, M=1023, P=1, P=63, S=1 and S=5 are accepted.
- R10: pll_m, pll_p and pll_s always equal the M, P and S fields read back on rd_data.
- R11: An enabled write that repeats the current M and P does not restart the wait or drop pll_locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| lowpwr_req | input | 1 | Low-power entry request; forces the synthesizer off |
| rd_data | output | 32 | Current control word with the lock flag |
| pll_en | output | 1 | Enable to the analog loop |
| pll_m | output | 10 | Feedback divider setting |
| pll_p | output | 6 | Pre-divider setting |
| pll_s | output | 3 | Post-divider setting |
| pll_locked | output | 1 | Output valid flag |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
The selective relock is tested with three kinds of enabled write: one that changes only S, one that changes M, and one that repeats the current M and P. Only the M change may drop the lock flag, so these writes separate a correct change detector from one that fires on any write or never fires. Out-of-range writes change one field at a time, and the boundary values are then written, so that each inclusive limit is shown to be in the right place. Low-power requests arrive both alone and together with an enabling write, to show that the forced shutdown beats software while the divider fields still load.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
    localparam int M_W      = 10;
    localparam int P_W      = 6;
    localparam int S_W      = 3;
    localparam int EN_BIT   = 31;
    localparam int LOCK_BIT = 29;
    localparam int M_LSB    = 16;
    localparam int P_LSB    = 8;
    localparam int S_LSB    = 0;
    localparam int M_MIN    = 64;
    localparam int M_MAX    = 1023;
    localparam int P_MIN    = 1;
    localparam int P_MAX    = 63;
    localparam int S_MIN    = 1;
    localparam int S_MAX    = 5;
    localparam int M_RST    = 200;
    localparam int P_RST    = 3;
    localparam int S_RST    = 1;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [P_W-1:0] p;
        logic [S_W-1:0] s;
    } div_set_t;

    typedef struct packed {
        logic     en;
        div_set_t div;
        logic     err;
    } ctl_reg_t;
endpackage

// File: rtl/pll_range_chk.sv
module pll_range_chk #(
    parameter int W  = 8,
    parameter int LO = 0,
    parameter int HI = 255
) (
    input  logic [W-1:0] val,
    output logic         ok
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);
    localparam bit HI_NEEDED = (HI < (2 ** W) - 1);
    localparam bit LO_NEEDED = (LO > 0);

    logic lo_ok;
    logic hi_ok;

    generate
        if (LO_NEEDED) begin : g_lo
            assign lo_ok = (val >= LO_V);
        end else begin : g_lo_none
            assign lo_ok = 1'b1;
        end
        if (HI_NEEDED) begin : g_hi
            assign hi_ok = (val <= HI_V);
        end else begin : g_hi_none
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign ok = lo_ok & hi_ok;
endmodule

// File: rtl/pll_div_check.sv
module pll_div_check
    import pll_ctl_pkg::*;
(
    input  div_set_t cand,
    output logic     legal
);
    logic m_ok;
    logic p_ok;
    logic s_ok;

    pll_range_chk #(.W(M_W), .LO(M_MIN), .HI(M_MAX)) u_m_rng (.val(cand.m), .ok(m_ok));
    pll_range_chk #(.W(P_W), .LO(P_MIN), .HI(P_MAX)) u_p_rng (.val(cand.p), .ok(p_ok));
    pll_range_chk #(.W(S_W), .LO(S_MIN), .HI(S_MAX)) u_s_rng (.val(cand.s), .ok(s_ok));

    assign legal = m_ok & p_ok & s_ok;
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LOCK_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(LOCK_CYCLES);
    localparam logic [CW-1:0] ONE_V  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          locked;
    } tmr_t;

    tmr_t t_d;
    tmr_t t_q;

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d.cnt    = '0;
            t_d.locked = 1'b0;
        end else if (load) begin
            t_d.cnt    = LOAD_V;
            t_d.locked = 1'b0;
        end else if (t_q.cnt != '0) begin
            t_d.cnt    = t_q.cnt - ONE_V;
            t_d.locked = (t_q.cnt == ONE_V);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign locked = t_q.locked;
endmodule

// File: rtl/pll_ctl_top.sv
module pll_ctl_top
    import pll_ctl_pkg::*;
#(
    parameter int LOCK_CYCLES = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [31:0]    wr_data,
    input  logic           lowpwr_req,
    output logic [31:0]    rd_data,
    output logic           pll_en,
    output logic [M_W-1:0] pll_m,
    output logic [P_W-1:0] pll_p,
    output logic [S_W-1:0] pll_s,
    output logic           pll_locked,
    output logic           cfg_err
);
    localparam ctl_reg_t RST_V = '{
        en:  1'b0,
        div: '{m: M_W'(M_RST), p: P_W'(P_RST), s: S_W'(S_RST)},
        err: 1'b0
    };

    ctl_reg_t r_d;
    ctl_reg_t r_q;
    div_set_t cand;
    logic     legal;
    logic     tmr_clr;
    logic     tmr_load;
    logic     locked;

    assign cand.m = wr_data[M_LSB +: M_W];
    assign cand.p = wr_data[P_LSB +: P_W];
    assign cand.s = wr_data[S_LSB +: S_W];

    pll_div_check u_chk_div (
        .cand  (cand),
        .legal (legal)
    );

    always_comb begin
        r_d      = r_q;
        tmr_clr  = 1'b0;
        tmr_load = 1'b0;
        if (wr_en && legal) begin
            r_d.div = cand;
            r_d.en  = wr_data[EN_BIT] & ~lowpwr_req;
            if (!r_d.en) begin
                tmr_clr = 1'b1;
            end else if (!r_q.en || (cand.m != r_q.div.m) || (cand.p != r_q.div.p)) begin
                tmr_load = 1'b1;
            end
        end else if (lowpwr_req) begin
            r_d.en  = 1'b0;
            tmr_clr = 1'b1;
        end
        if (wr_en && !legal) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RST_V;
        end else begin
            r_q <= r_d;
        end
    end

    pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .load   (tmr_load),
        .locked (locked)
    );

    always_comb begin
        rd_data                 = '0;
        rd_data[EN_BIT]         = r_q.en;
        rd_data[LOCK_BIT]       = locked;
        rd_data[M_LSB +: M_W]   = r_q.div.m;
        rd_data[P_LSB +: P_W]   = r_q.div.p;
        rd_data[S_LSB +: S_W]   = r_q.div.s;
    end

    assign pll_en     = r_q.en;
    assign pll_m      = r_q.div.m;
    assign pll_p      = r_q.div.p;
    assign pll_s      = r_q.div.s;
    assign pll_locked = locked;
    assign cfg_err    = r_q.err;
endmodule

// File: rtl/pll_ctl_chk.sv
module pll_ctl_chk
    import pll_ctl_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [31:0]    wr_data,
    input logic           lowpwr_req,
    input logic [31:0]    rd_data,
    input logic           pll_en,
    input logic [M_W-1:0] pll_m,
    input logic [P_W-1:0] pll_p,
    input logic [S_W-1:0] pll_s,
    input logic           pll_locked,
    input logic           cfg_err
);
    logic [M_W-1:0] w_m;
    logic [P_W-1:0] w_p;
    logic [S_W-1:0] w_s;
    logic           w_ok;

    assign w_m  = wr_data[M_LSB +: M_W];
    assign w_p  = wr_data[P_LSB +: P_W];
    assign w_s  = wr_data[S_LSB +: S_W];
    assign w_ok = (int'(w_m) >= M_MIN) && (int'(w_p) >= P_MIN) &&
                  (int'(w_s) >= S_MIN) && (int'(w_s) <= S_MAX);

    AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pll_locked |-> pll_en); // R6
    AST_LOWPWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_req |=> (!pll_en && !pll_locked)); // R7
    AST_S_ONLY_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_ok && wr_data[EN_BIT] && !lowpwr_req && pll_en && pll_locked &&
         w_m == pll_m && w_p == pll_p) |=> pll_locked); // R5
    AST_MP_CHANGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_ok && pll_en && (w_m != pll_m || w_p != pll_p)) |=> !pll_locked); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R8
    AST_BAD_WRITE_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w_ok) |=> ($stable(pll_m) && $stable(pll_p) && $stable(pll_s))); // R8
    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pll_m) >= M_MIN) && (int'(pll_p) >= P_MIN) &&
        (int'(pll_s) >= S_MIN) && (int'(pll_s) <= S_MAX)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 32'h5C00_C0F8) == 32'h0); // R2
endmodule

bind pll_ctl_top pll_ctl_chk u_ctl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .lowpwr_req (lowpwr_req),
    .rd_data    (rd_data),
    .pll_en     (pll_en),
    .pll_m      (pll_m),
    .pll_p      (pll_p),
    .pll_s      (pll_s),
    .pll_locked (pll_locked),
    .cfg_err    (cfg_err)
);

// File: tb/pll_ctl_top_tb.sv
module pll_ctl_top_tb;
    localparam int LC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        lowpwr_req = 1'b0;
    logic [31:0] rd_data;
    logic        pll_en;
    logic [9:0]  pll_m;
    logic [5:0]  pll_p;
    logic [2:0]  pll_s;
    logic        pll_locked;
    logic        cfg_err;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  live = 1'b0;

    int  md_en, md_m, md_p, md_s, md_err, md_left, md_lock;

    always #2 clk = ~clk;

    pll_ctl_top #(.LOCK_CYCLES(LC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .lowpwr_req(lowpwr_req), .rd_data(rd_data), .pll_en(pll_en),
        .pll_m(pll_m), .pll_p(pll_p), .pll_s(pll_s),
        .pll_locked(pll_locked), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            md_en = 0; md_m = 200; md_p = 3; md_s = 1;
            md_err = 0; md_left = 0; md_lock = 0;
        end else begin
            int nm, np, ns;
            bit ok;
            nm = int'(wr_data[25:16]);
            np = int'(wr_data[13:8]);
            ns = int'(wr_data[2:0]);
            ok = nm >= 64 && nm <= 1023 && np >= 1 && np <= 63 && ns >= 1 && ns <= 5;
            if (wr_en && !ok) md_err = 1;
            if (wr_en && ok) begin
                bit go, restart;
                go = wr_data[31] && !lowpwr_req;
                restart = go && (md_en == 0 || nm != md_m || np != md_p);
                md_m = nm; md_p = np; md_s = ns;
                if (!go) begin
                    md_en = 0; md_lock = 0; md_left = 0;
                end else if (restart) begin
                    md_en = 1; md_lock = 0; md_left = LC;
                end else if (md_left > 0) begin
                    md_left--;
                    if (md_left == 0) md_lock = 1;
                end
            end else if (lowpwr_req) begin
                md_en = 0; md_lock = 0; md_left = 0;
            end else if (md_left > 0) begin
                md_left--;
                if (md_left == 0) md_lock = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            logic [31:0] exp_rd;
            exp_rd = {md_en[0], 1'b0, md_lock[0], 3'b0, md_m[9:0], 2'b0,
                      md_p[5:0], 5'b0, md_s[2:0]};
            chk("R2 rd_data", rd_data, exp_rd);
            chk("R6 pll_en", {31'b0, pll_en}, 32'(md_en));
            chk("R3 pll_locked", {31'b0, pll_locked}, 32'(md_lock));
            chk("R10 pll_m/p/s", {13'b0, pll_m, pll_p, pll_s},
                {13'b0, md_m[9:0], md_p[5:0], md_s[2:0]});
            chk("R8 cfg_err", {31'b0, cfg_err}, 32'(md_err));
        end
    end

    task automatic wr(input logic [31:0] d, input logic lp);
        wr_en = 1'b1; wr_data = d; lowpwr_req = lp;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; lowpwr_req = 1'b0;
    endtask

    task automatic wait_lock(output int n);
        n = 1;
        while (!pll_locked && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        chk("R1 reset word", rd_data, 32'h00C8_0301);
        chk("R1 reset flags", {30'b0, pll_en, cfg_err}, 32'h0);

        wr(32'h80C8_0301, 1'b0);
        wait_lock(n);
        chk("R3 lock latency", 32'(n), 32'(LC + 1));

        wr(32'h80C8_0302, 1'b0);                   // S only
        chk("R5 S-only keeps lock", {31'b0, pll_locked}, 32'h1);
        chk("R5 S applied", {29'b0, pll_s}, 32'h2);

        wr(32'h80C9_0302, 1'b0);                   // M change
        chk("R4 M change unlocks", {31'b0, pll_locked}, 32'h0);
        wait_lock(n);
        chk("R4 relock latency", 32'(n), 32'(LC + 1));

        wr(32'h80C9_0302, 1'b0);                   // same values
        chk("R11 rewrite keeps lock", {31'b0, pll_locked}, 32'h1);

        wr(32'hFCC9_C3FA, 1'b0);                   // reserved and lock bits set
        chk("R2 reserved ignored", rd_data, 32'hA0C9_0302);

        wr(32'h803F_0302, 1'b0);                   // M=63
        chk("R8 M low rejected", {22'b0, pll_m}, 32'h0C9);
        chk("R8 err set", {31'b0, cfg_err}, 32'h1);
        wr(32'h80C9_0002, 1'b0);                   // P=0
        chk("R8 P zero rejected", {26'b0, pll_p}, 32'h3);
        wr(32'h80C9_0306, 1'b0);                   // S=6
        chk("R8 S high rejected", {29'b0, pll_s}, 32'h2);
        wr(32'h80C9_0300, 1'b0);                   // S=0
        chk("R8 S zero rejected", {29'b0, pll_s}, 32'h2);
        chk("R8 lock kept on reject", {31'b0, pll_locked}, 32'h1);

        wr(32'h83FF_3F05, 1'b0);
        chk("R9 upper bounds", {13'b0, pll_m, pll_p, pll_s}, {13'b0, 10'h3FF, 6'h3F, 3'h5});
        wr(32'h8040_0101, 1'b0);
        chk("R9 lower bounds", {13'b0, pll_m, pll_p, pll_s}, {13'b0, 10'h040, 6'h01, 3'h1});
        chk("R8 err sticky", {31'b0, cfg_err}, 32'h1);

        wait_lock(n);
        wr(32'h0040_0101, 1'b0);
        chk("R6 disable", {30'b0, pll_en, pll_locked}, 32'h0);
        repeat (3) @(negedge clk);
        wr(32'h8040_0101, 1'b0);
        wait_lock(n);
        chk("R6 full wait after re-enable", 32'(n), 32'(LC + 1));

        lowpwr_req = 1'b1;
        @(negedge clk);
        lowpwr_req = 1'b0;
        chk("R7 low-power off", {30'b0, pll_en, pll_locked}, 32'h0);
        wr(32'h8040_0105, 1'b1);
        chk("R7 lowpwr beats enable", {31'b0, pll_en}, 32'h0);
        chk("R7 dividers still load", {29'b0, pll_s}, 32'h5);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule